// File: doc/BRIEF.md
# Interrupt Pending and Acknowledge Controller

This block sits between a set of interrupt request lines and the instruction sequencer of a processor core. A rising transition on a request line is captured into a pending register, and the bit is captured whether or not the line is enabled. Each cycle the block looks at the pending bits, the enable mask and the late-arrival state. It registers the lowest-numbered eligible source as the candidate vector, and the core sees that candidate at its next instruction boundary. When the core takes the vector, the block clears the matching pending bit.

Software reaches four registers through a small select-and-write port. It can read and overwrite the primary pending register, which lets it cancel requests or raise them itself. It can program the primary enables, and one extra enable bit gates a summary request. A second group of event sources has its own pending and enable registers. These sources are merged into that summary request, which occupies the highest vector number and has the lowest priority.

The core drives three qualifiers. `restore_i` marks the register-restore instruction, and after it the next instruction boundary offers no vector. `late_i` marks the final state times of an instruction, and a request that becomes pending while it is high waits out one more boundary.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the primary pending, enable, secondary pending, secondary enable, late-arrival and inhibit state. `vec_req_o` is low in the cycle after reset, and every register reads as zero.
- R2: A 0-to-1 transition on `irq_line_i[i]` sets primary pending bit i one clock later, whatever the enable bit says. A line that stays high does not set the bit again once it has been cleared.
- R3: A write to select 0 replaces the primary pending register with `reg_wdata_i[NP-1:0]`, so software can both clear and raise requests. A rising edge on a line in the same cycle as the write leaves that bit set.
- R4: Select 1 holds the enables: bits NP-1..0 enable the primary sources and bit NP enables the summary request. Select 3 holds the secondary enables. Reads of every select appear on `reg_rdata_o` in the same cycle, with zeros above the register width.
- R5: In the cycle after the inputs to the choice change, `vec_id_o` shows the lowest-numbered primary source that is pending, enabled and not late. It shows NP when only the summary request is eligible. `vec_req_o` is high when any source is eligible and no inhibit is active.
- R6: When `bnd_i`, `vec_take_i` and `vec_req_o` are all high, the pending bit of the presented primary source is clear from the next clock, and `vec_req_o` is low in that next cycle.
- R7: A pulse on `restore_i` holds `vec_req_o` low from the next cycle until the next `bnd_i` has passed, so no vector is taken at that boundary.
- R8: A primary pending bit that becomes set while `late_i` is high is not eligible until one `bnd_i` cycle has passed after it was set.
- R9: A 0-to-1 transition on `sub_line_i[j]` sets secondary pending bit j whatever the secondary enables say. A write to select 2 clears each bit written as 1, and a rising edge in the same cycle still sets the bit.
- R10: The summary request, vector NP, is eligible while enable bit NP is set and any secondary bit is both pending and enabled. Taking vector NP leaves the secondary pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line_i | input | NP | Primary request lines, edge-detected |
| sub_line_i | input | NS | Secondary event lines, edge-detected |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 pending, 1 enable, 2 secondary pending, 3 secondary enable |
| reg_wdata_i | input | DW | Write data, DW = max(NP+1, NS) |
| reg_rdata_o | output | DW | Read data of the selected register |
| bnd_i | input | 1 | Instruction boundary strobe |
| late_i | input | 1 | High during the final state times of the current instruction |
| restore_i | input | 1 | Pulse marking the register-restore instruction |
| vec_take_i | input | 1 | Core takes the presented vector at this boundary |
| vec_req_o | output | 1 | Vector request to the sequencer |
| vec_id_o | output | IW | Vector number, IW = clog2(NP+1) |

## Verification
The bench builds the block with NP=6 and NS=3, so the summary request is vector 6 and fits in a 3-bit identifier. With only six primary lines, random stimulus often leaves several sources pending at once. It also often lines up edges with software writes, boundaries, late windows and restore pulses in the same cycle. With only three secondary lines, the summary request is often raised and dropped, and a take of vector 6 often falls in the same cycle as a secondary clear-on-write.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_PEND    = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_SUBPEND = 2'd2,
    SEL_SUBMASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  // The previous value is sampled even during reset, so a line held high
  // through reset does not count as an edge afterwards.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) prev_q[i] <= line_i[i];
    assign rise_o[i] = line_i[i] & ~prev_q[i] & ~rst;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NP = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] elig_i,
  input  logic          sum_req_i,
  input  logic          take_i,
  output logic          cand_v_o,
  output logic [IW-1:0] cand_id_o
);
  function automatic logic [IW-1:0] lowest_set(input logic [NP-1:0] v);
    logic [IW-1:0] r;
    r = IW'(NP);
    for (int i = NP - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_v_o  <= 1'b0;
      cand_id_o <= '0;
    end else begin
      cand_v_o  <= ~take_i & ((|elig_i) | sum_req_i);
      cand_id_o <= lowest_set(elig_i);
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pkg::*;
#(
  parameter int NP = 8,
  parameter int NS = 6,
  localparam int NV = NP + 1,
  localparam int IW = $clog2(NV),
  localparam int DW = (NV > NS) ? NV : NS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] irq_line_i,
  input  logic [NS-1:0] sub_line_i,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          bnd_i,
  input  logic          late_i,
  input  logic          restore_i,
  input  logic          vec_take_i,
  output logic          vec_req_o,
  output logic [IW-1:0] vec_id_o
);
  logic [NP-1:0] pend_q, pend_d, young_q, young_d;
  logic [NP-1:0] irq_rise_w, take_oh_w, elig_w;
  logic [NP:0]   mask_q;
  logic [NS-1:0] sub_pend_q, sub_pend_d, sub_mask_q, sub_rise_w;
  logic          inhib_q, cand_v_q, take_w, sum_req_w;
  logic [IW-1:0] cand_id_q;
  logic          wr_pend, wr_mask, wr_subpend, wr_submask;
  reg_sel_e      sel;

  assign sel        = reg_sel_e'(reg_addr_i);
  assign wr_pend    = reg_wr_i && (sel == SEL_PEND);
  assign wr_mask    = reg_wr_i && (sel == SEL_MASK);
  assign wr_subpend = reg_wr_i && (sel == SEL_SUBPEND);
  assign wr_submask = reg_wr_i && (sel == SEL_SUBMASK);

  irq_edge #(.W(NP)) u_irq_edge (
    .clk(clk), .rst(rst), .line_i(irq_line_i), .rise_o(irq_rise_w)
  );
  irq_edge #(.W(NS)) u_sub_edge (
    .clk(clk), .rst(rst), .line_i(sub_line_i), .rise_o(sub_rise_w)
  );

  // A vector is taken only when it is actually being presented.
  assign take_w = bnd_i & vec_take_i & vec_req_o;

  always_comb begin
    for (int i = 0; i < NP; i++) take_oh_w[i] = take_w && (cand_id_q == IW'(i));
  end

  // Order of effects: software write, then the take clears the bit, then a
  // hardware edge sets it.
  always_comb begin
    pend_d = wr_pend ? reg_wdata_i[NP-1:0] : pend_q;
    pend_d = (pend_d & ~take_oh_w) | irq_rise_w;
  end

  // A bit that becomes pending during the late window waits out one boundary.
  always_comb begin
    young_d = bnd_i ? '0 : young_q;
    young_d = young_d | (pend_d & ~pend_q & {NP{late_i}});
  end

  always_comb begin
    sub_pend_d = wr_subpend ? (sub_pend_q & ~reg_wdata_i[NS-1:0]) : sub_pend_q;
    sub_pend_d = sub_pend_d | sub_rise_w;
  end

  assign elig_w    = pend_q & mask_q[NP-1:0] & ~young_q;
  assign sum_req_w = mask_q[NP] & (|(sub_pend_q & sub_mask_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      young_q    <= '0;
      mask_q     <= '0;
      sub_pend_q <= '0;
      sub_mask_q <= '0;
      inhib_q    <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      young_q    <= young_d;
      sub_pend_q <= sub_pend_d;
      if (wr_mask)    mask_q     <= reg_wdata_i[NP:0];
      if (wr_submask) sub_mask_q <= reg_wdata_i[NS-1:0];
      if (restore_i)  inhib_q    <= 1'b1;
      else if (bnd_i) inhib_q    <= 1'b0;
    end
  end

  irq_pick #(.NP(NP), .IW(IW)) u_pick (
    .clk(clk), .rst(rst), .elig_i(elig_w), .sum_req_i(sum_req_w),
    .take_i(take_w), .cand_v_o(cand_v_q), .cand_id_o(cand_id_q)
  );

  assign vec_req_o = cand_v_q & ~inhib_q;
  assign vec_id_o  = cand_id_q;

  always_comb begin
    unique case (sel)
      SEL_PEND:    reg_rdata_o = DW'(pend_q);
      SEL_MASK:    reg_rdata_o = DW'(mask_q);
      SEL_SUBPEND: reg_rdata_o = DW'(sub_pend_q);
      default:     reg_rdata_o = DW'(sub_mask_q);
    endcase
  end
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
  parameter int NP = 8,
  parameter int NS = 6,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          vec_req_o,
  input logic [IW-1:0] vec_id_o,
  input logic          restore_i,
  input logic          take_w,
  input logic [NP-1:0] irq_rise_w,
  input logic [NP-1:0] pend_q,
  input logic [NS-1:0] sub_rise_w,
  input logic [NS-1:0] sub_pend_q
);
  logic [NP-1:0] gone_w;

  always_comb begin
    for (int i = 0; i < NP; i++)
      gone_w[i] = take_w && (vec_id_o == IW'(i)) && !irq_rise_w[i];
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !vec_req_o);

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (|irq_rise_w) |=> ((pend_q & $past(irq_rise_w)) == $past(irq_rise_w)));

  a_r5_id_range: assert property (@(posedge clk) disable iff (rst)
    vec_req_o |-> (vec_id_o <= IW'(NP)));

  a_r6_take_clears: assert property (@(posedge clk) disable iff (rst)
    (|gone_w) |=> ((pend_q & $past(gone_w)) == '0));

  a_r6_req_drops: assert property (@(posedge clk) disable iff (rst)
    take_w |=> !vec_req_o);

  a_r7_restore_blocks: assert property (@(posedge clk) disable iff (rst)
    restore_i |=> !vec_req_o);

  a_r9_sub_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (|sub_rise_w) |=> ((sub_pend_q & $past(sub_rise_w)) == $past(sub_rise_w)));
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NP(NP), .NS(NS), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .vec_req_o(vec_req_o), .vec_id_o(vec_id_o),
  .restore_i(restore_i), .take_w(take_w), .irq_rise_w(irq_rise_w),
  .pend_q(pend_q), .sub_rise_w(sub_rise_w), .sub_pend_q(sub_pend_q)
);

// File: tb/test_irq_pend_ctrl.sv
module test_irq_pend_ctrl;
  localparam int NP = 6;
  localparam int NS = 3;
  localparam int IW = 3;
  localparam int DW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] line = '0;
  logic [NS-1:0] sub = '0;
  logic wr = 1'b0, bnd = 1'b0, late = 1'b0, restore = 1'b0, take = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic vreq;
  logic [IW-1:0] vid;

  int tests = 0, fails = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  irq_pend_ctrl #(.NP(NP), .NS(NS)) i_irq_pend_ctrl (
    .clk(clk), .rst(rst), .irq_line_i(line), .sub_line_i(sub),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .bnd_i(bnd), .late_i(late), .restore_i(restore), .vec_take_i(take),
    .vec_req_o(vreq), .vec_id_o(vid)
  );

  // Behavioural reference model.
  logic [NP-1:0] m_pend, m_young, m_line_prev;
  logic [NP:0]   m_mask;
  logic [NS-1:0] m_spend, m_smask, m_sub_prev;
  logic m_inhib, m_cv;
  int   m_cid;

  always @(posedge clk) begin : model
    logic [NP-1:0] edg, pn, el;
    logic [NS-1:0] sedg, sn;
    logic tk, sumr;
    int id;
    edg  = line & ~m_line_prev;
    sedg = sub & ~m_sub_prev;
    m_line_prev = line;
    m_sub_prev  = sub;
    if (rst) begin
      m_pend = '0; m_young = '0; m_mask = '0; m_spend = '0; m_smask = '0;
      m_inhib = 0; m_cv = 0; m_cid = 0;
    end else begin
      tk = bnd && take && m_cv && !m_inhib;
      pn = (wr && addr == 2'd0) ? wdata[NP-1:0] : m_pend;
      if (tk && m_cid < NP) pn[m_cid] = 1'b0;
      pn = pn | edg;
      sn = m_spend;
      if (wr && addr == 2'd2) sn = sn & ~wdata[NS-1:0];
      sn = sn | sedg;
      el = m_pend & m_mask[NP-1:0] & ~m_young;
      sumr = m_mask[NP] && ((m_spend & m_smask) != 0);
      id = NP;
      for (int i = 0; i < NP; i++) if (el[i] && id == NP) id = i;
      m_cv  = !tk && (el != 0 || sumr);
      m_cid = id;
      m_young = (bnd ? '0 : m_young) | (pn & ~m_pend & {NP{late}});
      m_pend  = pn;
      m_spend = sn;
      if (wr && addr == 2'd1) m_mask  = wdata[NP:0];
      if (wr && addr == 2'd3) m_smask = wdata[NS-1:0];
      if (restore) m_inhib = 1;
      else if (bnd) m_inhib = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [DW-1:0] er;
    case (addr)
      2'd0: er = DW'(m_pend);
      2'd1: er = DW'(m_mask);
      2'd2: er = DW'(m_spend);
      default: er = DW'(m_smask);
    endcase
    chk({phase, " vec_req"}, int'(vreq), int'(m_cv && !m_inhib));
    chk({phase, " vec_id"}, int'(vid), m_cid);
    chk({phase, " rdata"}, int'(rdata), int'(er));
  endtask

  task automatic step();
    #1 compare();
    @(negedge clk);
    wr = 0; bnd = 0; restore = 0; take = 0;
  endtask

  task automatic wreg(input logic [1:0] a, input int v);
    addr = a; wdata = DW'(v); wr = 1; step();
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset with lines high
    line = 6'b000011; rst = 1;
    step(); step(); step();
    rst = 0; line = '0;
    step();
    chk("R1 vec_req after reset", int'(vreq), 0);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1 chk("R1 reg zero", int'(rdata), 0); step();
    end

    // R2: masked edge still latches; held line does not re-latch
    phase = "R2"; addr = 0;
    line[2] = 1; step(); step();
    chk("R2 masked edge", int'(rdata), 4);
    wreg(0, 0); step();
    chk("R2 held line no relatch", int'(rdata), 0);
    line[2] = 0; step();

    // R3: software set/clear, edge wins over write
    phase = "R3";
    wreg(0, 6'b100001); addr = 0; step();
    chk("R3 sw write", int'(rdata), 33);
    line[4] = 1; wreg(0, 0); addr = 0; step();
    chk("R3 edge wins", int'(rdata), 16);
    line[4] = 0; wreg(0, 0);

    // R4: enable and secondary enable readback
    phase = "R4";
    wreg(1, 7'h7f); addr = 1; step();
    chk("R4 mask readback", int'(rdata), 127);
    wreg(3, 3'b101); addr = 3; step();
    chk("R4 submask readback", int'(rdata), 5);

    // R5: lowest of sources 3 and 5
    phase = "R5";
    wreg(0, 6'b101000); addr = 0; step(); step();
    chk("R5 req", int'(vreq), 1);
    chk("R5 lowest id", int'(vid), 3);

    // R6: take source 3
    phase = "R6";
    bnd = 1; take = 1; step();
    chk("R6 req drops", int'(vreq), 0);
    chk("R6 bit cleared", int'(rdata), 32);
    step();
    chk("R6 next id", int'(vid), 5);

    // R7: restore inhibits the next boundary
    phase = "R7";
    restore = 1; step();
    chk("R7 req held low", int'(vreq), 0);
    bnd = 1; take = 1; step();
    chk("R7 not taken", int'(rdata), 32);
    chk("R7 req back", int'(vreq), 1);
    bnd = 1; take = 1; step(); step();
    chk("R7 later taken", int'(rdata), 0);

    // R8: late arrival waits one boundary
    phase = "R8";
    late = 1; line[1] = 1; step();
    late = 0; step(); step(); step();
    chk("R8 late not eligible", int'(vreq), 0);
    bnd = 1; take = 1; step();
    chk("R8 still pending", int'(rdata), 2);
    step();
    chk("R8 eligible after bnd", int'(vreq), 1);
    chk("R8 id", int'(vid), 1);
    bnd = 1; take = 1; step(); line[1] = 0; step();

    // R9: secondary edges, W1C, edge wins
    phase = "R9"; addr = 2;
    sub = 3'b010; step(); step();
    chk("R9 masked sub edge", int'(rdata), 2);
    sub = 3'b011; wreg(2, 3'b011); addr = 2; step();
    chk("R9 edge wins w1c", int'(rdata), 1);
    sub = 0; wreg(2, 3'b001); addr = 2; step();
    chk("R9 w1c", int'(rdata), 0);

    // R10: summary request
    phase = "R10";
    sub[2] = 1; step(); step(); step();
    chk("R10 summary id", int'(vid), NP);
    chk("R10 summary req", int'(vreq), 1);
    bnd = 1; take = 1; addr = 2; step();
    chk("R10 sub kept", int'(rdata), 4);
    wreg(1, 6'h3f); step(); step();
    chk("R10 summary disabled", int'(vreq), 0);
    sub = 0;

    // Mixed random traffic: R2 R3 R5 R6 R7 R8 R9 R10
    phase = "MIX";
    for (int n = 0; n < 4000; n++) begin
      line    = NP'($urandom);
      sub     = NS'($urandom);
      wr      = ($urandom % 6) == 0;
      addr    = 2'($urandom);
      wdata   = DW'($urandom);
      bnd     = ($urandom % 3) == 0;
      take    = bnd && ($urandom % 4 != 0);
      late    = ($urandom % 3) == 0;
      restore = ($urandom % 9) == 0;
      rst     = ($urandom % 400) == 0;
      step();
    end
    rst = 0; step();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule